// File: doc/BRIEF.md
# Dual-Mode Shared Memory Arbiter

Eight processor cores share one internal synchronous RAM through this arbiter. The RAM performs at most one access every two clocks. The owner of each access window rotates through the cores in index order 0 to 7, so a full rotation takes 16 clocks. Each core picks one of two service modes with its own mode bit.

A core in slotted mode is served only in its own window. Its access timing is therefore fixed, whatever the other cores do. A core in queued mode may raise a request at any clock. The request joins a shared first-in first-out queue, which is drained in every window whose owner is in queued mode. This lets a busy queued core reach the memory more often than once per rotation. A slotted core's window that carries no request stays idle; it is never lent to the queue.

Each core holds its request, write-enable, address and write data stable until its done pulse. It drops the request in the cycle it sees done, or keeps the request high in that cycle to start the next access with new fields. A core may have only one outstanding request. With eight cores the queue never holds more than eight entries, so it cannot overflow.

Top module: `dualmode_mem_arbiter`

## Requirements
- R1: Counting the first cycle after reset release as cycle 0, an access window opens in every cycle whose index is even. The window in cycle n belongs to core (n mod 16)/2, so core k owns the cycles where n mod 16 equals 2k. No two consecutive cycles carry a grant.
- R2: The mode bit value 0 selects slotted mode. A core in slotted mode whose request is high in its own window is granted in that window, and it is never granted in any other window.
- R3: A window owned by a slotted core that has no request is idle: no grant is given, even when the queue holds entries.
- R4: The mode bit value 1 selects queued mode. A queued core's request enters the queue at a clock edge. Queued requests are served in arrival order, one per window, in windows whose owner is in queued mode. When several cores become eligible at the same edge, only the lowest-numbered one enters the queue at that edge; the others enter at the following edges.
- R5: A queued core has at most one outstanding request. It is not queued again in the cycle it is served or in its done cycle, so every request is served exactly once.
- R6: At most one grant bit is high in any cycle. A write takes effect in the memory at the end of its grant cycle.
- R7: The done bit of the served core alone pulses high for one cycle, in the cycle after the grant. For a read, rdData carries the word from the addressed location during that done cycle.
- R8: A change of a core's mode bit takes effect only at a clock edge where that core's request is low and it has no entry in the queue.
- R9: After reset all cores are in slotted mode, the queue is empty, the window pointer is at core 0, and done and rdData are zero.
- R10: A queued core that issues back-to-back requests while other queued windows are free completes more than one access per 16 clocks on average.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| modeSel | input | NUM_CORES | Per-core mode bit: 0 slotted, 1 queued |
| reqValid | input | NUM_CORES | Per-core request, held until done |
| reqWe | input | NUM_CORES | Per-core write enable, 1 for a write |
| reqAddr | input | NUM_CORES*ADDR_W | Per-core word address; core k uses bits [k*ADDR_W +: ADDR_W] |
| reqWdata | input | NUM_CORES*DATA_W | Per-core write data; core k uses bits [k*DATA_W +: DATA_W] |
| grant | output | NUM_CORES | One-hot: the core whose access is performed in this cycle |
| done | output | NUM_CORES | One-cycle completion pulse to the served core |
| rdData | output | DATA_W | Read data, valid with done for a read |

## Verification
The bench attacks several corner cases. In the first, a slotted core sits idle while the queue is loaded; a design that lends the idle window to the queue shows a grant in core 0's window. In the second, a core changes its mode bit while its queued request is still waiting; a design that applies the change at once either serves the request in the wrong window or drops it. In the third, all eight cores become eligible in the same cycle; a design that does not admit them one per edge in index order returns the done pulses out of order. Back-to-back requests from one queued core check that the request is not queued a second time during its service or done cycle, which would show as an extra grant and an extra done.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned MAX_SEL_W = 8;

  typedef enum logic {
    MODE_SLOT  = 1'b0,
    MODE_QUEUE = 1'b1
  } coreMode_e;

  typedef struct packed {
    logic                 memEn;
    logic                 memWe;
    logic [MAX_SEL_W-1:0] sel;
  } ctlStrb_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int unsigned NUM_CORES = 8,
  parameter int unsigned WIN_CLKS  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CORES-1:0] reqValid,
  input  logic [NUM_CORES-1:0] reqWe,
  input  logic [NUM_CORES-1:0] modeSel,
  input  logic [NUM_CORES-1:0] done,
  output logic [NUM_CORES-1:0] grant,
  output ctlStrb_t             strb
);
  localparam int unsigned IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam int unsigned CNT_W = IDX_W + 1;
  localparam int unsigned PH_W  = (WIN_CLKS > 1) ? $clog2(WIN_CLKS) : 1;

  logic [PH_W-1:0]      phase;
  logic [IDX_W-1:0]     slot;
  logic [NUM_CORES-1:0] modeEff;
  logic [NUM_CORES-1:0] pend;
  logic [IDX_W-1:0]     fifoMem [NUM_CORES];
  logic [IDX_W-1:0]     rdPtr, wrPtr;
  logic [CNT_W-1:0]     fifoCnt;

  logic                 winOpen, slotIsQueued, serveSlot, serveQueue, serveAny;
  logic [IDX_W-1:0]     serveId, pushId;
  logic                 pushHit;
  logic [NUM_CORES-1:0] eligible, pushVec, popVec;

  // window timing
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      slot  <= '0;
    end else if (phase == PH_W'(WIN_CLKS - 1)) begin
      phase <= '0;
      slot  <= (slot == IDX_W'(NUM_CORES - 1)) ? '0 : slot + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  // service decision for the current cycle
  always_comb begin
    winOpen      = (phase == '0);
    slotIsQueued = (modeEff[slot] == MODE_QUEUE);
    serveSlot    = winOpen && !slotIsQueued && reqValid[slot];
    serveQueue   = winOpen && slotIsQueued && (fifoCnt != '0);
    serveAny     = serveSlot || serveQueue;
    serveId      = serveSlot ? slot : fifoMem[rdPtr];
    grant        = '0;
    if (serveAny) grant[serveId] = 1'b1;
    popVec       = serveQueue ? grant : '0;
  end

  // admission: one new queued request per edge, lowest index first
  always_comb begin
    eligible = reqValid & modeEff & ~pend & ~done & ~grant;
    pushHit  = 1'b0;
    pushId   = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        pushHit = 1'b1;
        pushId  = IDX_W'(i);
      end
    end
    pushVec = '0;
    if (pushHit) pushVec[pushId] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr   <= '0;
      wrPtr   <= '0;
      fifoCnt <= '0;
      pend    <= '0;
      modeEff <= '0;
    end else begin
      if (pushHit) wrPtr <= (wrPtr == IDX_W'(NUM_CORES - 1)) ? '0 : wrPtr + 1'b1;
      if (serveQueue) rdPtr <= (rdPtr == IDX_W'(NUM_CORES - 1)) ? '0 : rdPtr + 1'b1;
      case ({pushHit, serveQueue})
        2'b10:   fifoCnt <= fifoCnt + 1'b1;
        2'b01:   fifoCnt <= fifoCnt - 1'b1;
        default: fifoCnt <= fifoCnt;
      endcase
      pend <= (pend & ~popVec) | pushVec;
      for (int i = 0; i < NUM_CORES; i++) begin
        if (!reqValid[i] && !pend[i]) modeEff[i] <= modeSel[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pushHit) fifoMem[wrPtr] <= pushId;
  end

  always_comb begin
    strb.memEn = serveAny;
    strb.memWe = reqWe[serveId];
    strb.sel   = MAX_SEL_W'(serveId);
  end
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int unsigned NUM_CORES = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CORES*ADDR_W-1:0] reqAddr,
  input  logic [NUM_CORES*DATA_W-1:0] reqWdata,
  input  ctlStrb_t                    strb,
  output logic [NUM_CORES-1:0]        done,
  output logic [DATA_W-1:0]           rdData
);
  localparam int unsigned IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrArr [NUM_CORES];
  logic [DATA_W-1:0] dataArr [NUM_CORES];
  logic [DATA_W-1:0] mem     [DEPTH];
  logic [IDX_W-1:0]  curId;
  logic [ADDR_W-1:0] curAddr;
  logic [NUM_CORES-1:0] selVec;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_unpack
    assign addrArr[g] = reqAddr[g*ADDR_W +: ADDR_W];
    assign dataArr[g] = reqWdata[g*DATA_W +: DATA_W];
  end

  always_comb begin
    curId   = strb.sel[IDX_W-1:0];
    curAddr = addrArr[curId];
    selVec  = '0;
    selVec[curId] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.memEn && strb.memWe) mem[curAddr] <= dataArr[curId];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= '0;
      rdData <= '0;
    end else begin
      done <= strb.memEn ? selVec : '0;
      if (strb.memEn && !strb.memWe) rdData <= mem[curAddr];
    end
  end
endmodule

// File: rtl/dualmode_mem_arbiter.sv
module dualmode_mem_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned NUM_CORES = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned WIN_CLKS  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CORES-1:0]        modeSel,
  input  logic [NUM_CORES-1:0]        reqValid,
  input  logic [NUM_CORES-1:0]        reqWe,
  input  logic [NUM_CORES*ADDR_W-1:0] reqAddr,
  input  logic [NUM_CORES*DATA_W-1:0] reqWdata,
  output logic [NUM_CORES-1:0]        grant,
  output logic [NUM_CORES-1:0]        done,
  output logic [DATA_W-1:0]           rdData
);
  ctlStrb_t strb;

  arb_ctrl #(.NUM_CORES(NUM_CORES), .WIN_CLKS(WIN_CLKS)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWe(reqWe),
    .modeSel(modeSel), .done(done), .grant(grant), .strb(strb)
  );

  arb_datapath #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .strb(strb), .done(done), .rdData(rdData)
  );
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int unsigned NUM_CORES = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_CORES-1:0] reqValid,
  input logic [NUM_CORES-1:0] grant,
  input logic [NUM_CORES-1:0] done
);
  // R6
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R1
  window_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (|grant) |=> !(|grant));

  // R7
  done_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (|grant) |=> (done == $past(grant)));

  // R7
  no_idle_done_chk: assert property (@(posedge clk) disable iff (rst)
    !(|grant) |=> (done == '0));

  // R2
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    (grant & ~reqValid) == '0);
endmodule

bind dualmode_mem_arbiter arb_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .grant(grant), .done(done)
);

// File: tb/dualmode_mem_arbiter_tb.sv
module dualmode_mem_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC-1:0] modeSel = '0, reqValid = '0, reqWe = '0;
  logic [AW-1:0] addrA [NC];
  logic [DW-1:0] wdA   [NC];
  logic [NC*AW-1:0] reqAddrF;
  logic [NC*DW-1:0] reqWdataF;
  logic [NC-1:0] grant, done;
  logic [DW-1:0] rdData;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      reqAddrF[i*AW +: AW]  = addrA[i];
      reqWdataF[i*DW +: DW] = wdA[i];
    end
  end

  dualmode_mem_arbiter #(.NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .modeSel(modeSel), .reqValid(reqValid), .reqWe(reqWe),
    .reqAddr(reqAddrF), .reqWdata(reqWdataF), .grant(grant), .done(done), .rdData(rdData)
  );

  int tests = 0, fails = 0;
  task automatic check(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int            mCnt;
  int            mQ[$];
  bit            mPend [NC];
  bit            mMode [NC];
  logic [NC-1:0] mDone;
  logic [DW-1:0] mRd;
  bit            mRdValid;
  logic [DW-1:0] mMem [int];
  int            cyc;

  // directed observation
  bit phaseB = 0;
  int slot0Hits = 0, done5Cnt = 0, lastG5 = -1, lastG3 = -1;
  int doneOrder[$];

  always @(posedge clk) begin
    if (rst) begin
      mCnt = 0; mQ.delete(); mDone = '0; mRdValid = 0; cyc = 0;
      for (int i = 0; i < NC; i++) begin mPend[i] = 0; mMode[i] = 0; end
    end else begin
      bit pendOld [NC];
      int slotNow, serve;
      logic [NC-1:0] nd;
      for (int i = 0; i < NC; i++) pendOld[i] = mPend[i];
      slotNow = mCnt / 2; serve = -1; nd = '0;
      if (mCnt % 2 == 0) begin
        if (!mMode[slotNow]) begin
          if (reqValid[slotNow]) serve = slotNow;
        end else if (mQ.size() > 0) begin
          serve = mQ.pop_front();
          mPend[serve] = 0;
        end
      end
      mRdValid = 0;
      if (serve >= 0) begin
        nd[serve] = 1'b1;
        if (reqWe[serve]) mMem[int'(addrA[serve])] = wdA[serve];
        else if (mMem.exists(int'(addrA[serve]))) begin
          mRd = mMem[int'(addrA[serve])]; mRdValid = 1;
        end
      end
      for (int i = 0; i < NC; i++) begin
        if (reqValid[i] && mMode[i] && !mPend[i] && !mDone[i] && i != serve) begin
          mQ.push_back(i); mPend[i] = 1; break;
        end
      end
      for (int i = 0; i < NC; i++)
        if (!reqValid[i] && !pendOld[i]) mMode[i] = modeSel[i];
      mDone = nd;
      mCnt = (mCnt + 1) % 16;
      cyc++;
    end
    #2;
    if (!rst) begin
      logic [NC-1:0] expG;
      expG = '0;
      if (mCnt % 2 == 0) begin
        if (!mMode[mCnt/2]) begin
          if (reqValid[mCnt/2]) expG[mCnt/2] = 1'b1;
        end else if (mQ.size() > 0) expG[mQ[0]] = 1'b1;
      end
      check(grant == expG, "R2 R3 R4 R6 grant", grant, expG);
      check(done == mDone, "R7 done", done, mDone);
      if ((|mDone) && mRdValid) check(rdData == mRd, "R7 rdData", rdData, mRd);
      if (grant[5]) lastG5 = cyc;
      if (grant[3]) lastG3 = cyc;
      if (phaseB && (cyc % 16 == 0) && (|grant)) slot0Hits++;
      if (done[5]) done5Cnt++;
      for (int i = 0; i < NC; i++) if (done[i]) doneOrder.push_back(i);
    end
  end

  task automatic doAccess(int c, bit we, int a, logic [DW-1:0] d);
    reqValid[c] = 1'b1; reqWe[c] = we; addrA[c] = AW'(a); wdA[c] = d;
    @(negedge clk);
    while (!done[c]) @(negedge clk);
    reqValid[c] = 1'b0;
  endtask

  task automatic coreRun(int c, int n, int base);
    @(negedge clk);
    for (int k = 0; k < n; k++)
      doAccess(c, 1'b1, base + c*8 + k, DW'(c * 32'h01010101) ^ DW'(k * 32'h1111) ^ DW'(base));
    for (int k = 0; k < n; k++)
      doAccess(c, 1'b0, base + c*8 + k, '0);
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk); @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NC; i++) begin addrA[i] = '0; wdA[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(done == '0, "R9 done after reset", done, 0);
    check(grant == '0, "R9 grant idle after reset", grant, 0);
    check(rdData == '0, "R9 rdData after reset", rdData, 0);

    // R1 R2: all slotted, core 5 alone
    doAccess(5, 1'b1, 200, 32'hCAFE0005);
    check(lastG5 % 16 == 10, "R1 core 5 window position", lastG5 % 16, 10);
    @(negedge clk);
    doAccess(5, 1'b0, 200, '0);
    check(lastG5 % 16 == 10, "R2 slotted core served only in own window", lastG5 % 16, 10);

    // all slotted, all cores busy
    for (int c = 0; c < NC; c++) begin
      automatic int cc = c;
      fork coreRun(cc, 2, 0); join_none
    end
    wait fork;
    settle();

    // R3: core 0 slotted and idle, others queued
    modeSel = 8'hFE;
    settle();
    phaseB = 1;
    for (int c = 1; c < NC; c++) begin
      automatic int cc = c;
      fork coreRun(cc, 4, 64); join_none
    end
    wait fork;
    phaseB = 0;
    check(slot0Hits == 0, "R3 idle slotted window not lent", slot0Hits, 0);
    settle();

    // R10 R5: one queued core back to back
    begin
      int startCyc;
      done5Cnt = 0;
      startCyc = cyc;
      coreRun(5, 4, 128);
      check((cyc - startCyc) < 8 * 16, "R10 more than one access per 16 clocks", cyc - startCyc, 8*16);
      check(done5Cnt == 8, "R5 each request served once", done5Cnt, 8);
    end
    settle();

    // R8: mode change while queued request waits
    @(negedge clk);
    fork
      doAccess(3, 1'b1, 250, 32'h0B0B0B0B);
      begin @(negedge clk); modeSel[3] = 1'b0; end
    join
    @(negedge clk);
    doAccess(3, 1'b0, 250, '0);
    check(lastG3 % 16 == 6, "R8 new mode used after drain", lastG3 % 16, 6);
    settle();

    // R4: all queued, simultaneous arrival
    modeSel = 8'hFF;
    settle();
    doneOrder.delete();
    for (int c = 0; c < NC; c++) begin
      automatic int cc = c;
      fork begin @(negedge clk); doAccess(cc, 1'b0, cc*8, '0); end join_none
    end
    wait fork;
    check(doneOrder.size() == NC, "R4 all served", doneOrder.size(), NC);
    for (int i = 0; i < NC && i < doneOrder.size(); i++)
      check(doneOrder[i] == i, "R4 arrival order", doneOrder[i], i);
    settle();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule